// File: doc/BRIEF.md
# Reply Timeslot Scheduler

This block decides when a node on a shared half-duplex bus may turn on its line driver. A free-running counter advances once per timebase tick and wraps at a fixed modulus. When a master request begins, the block latches the counter as the reference for that request. It then waits for this node's own slot, which starts a configured offset after the reference plus the slot index times the slot length. The slot window stays open for the full slot length. A reply does not have to be ready for the window to open, and a reply may answer an earlier request that was tagged with a sequence number elsewhere. Because access is timed from the start of each request and not from its end, the software that builds the reply has the whole wait to finish its work.

Nodes share the slots that follow a request in rotating groups. A request is followed by `2^cfg_q_log2_i` slots. The low `cfg_q_log2_i` bits of the node identity select the slot inside the group, and the remaining upper bits select the group. A group counter picks which group owns the slots after each request. The counter steps on every accepted request start and wraps after `cfg_groups_i` groups. A node uses its slot even when the request was addressed to a different node.

The controller has four states. ST_IDLE waits for a request. ST_WAIT counts toward the slot start. ST_OPEN is the first cycle of the window. ST_HOLD covers the rest of the window. The transitions are as follows:
- ST_IDLE moves to ST_WAIT on a request start in the node's group, and stays in ST_IDLE on a request for another group.
- ST_WAIT restarts on a new request in its group, drops to ST_IDLE on a new request for another group, and moves to ST_OPEN when the elapsed count reaches the slot start.
- ST_OPEN moves to ST_HOLD, or to ST_IDLE if the elapsed count has already reached the slot end.
- ST_HOLD moves to ST_IDLE when the elapsed count reaches the slot end.

Top module: `slot_sched`

## Requirements
- R1: The tick counter counts from 0 to TICK_MOD-1 and then wraps to 0. The elapsed count since the reference is `now - ref` when `now >= ref`, and `now + (TICK_MOD - ref)` otherwise. Slot timing is therefore the same when the reference lies just below the wrap point.
- R2: A `sor_i` pulse that is accepted latches the current counter value as the reference. The slot start is `cfg_offset_i + (node_id_i & (2^cfg_q_log2_i - 1)) * cfg_slot_len_i` ticks after the reference. `slot_active_o` rises on the cycle after the tick that brings the elapsed count to the slot start, and never earlier.
- R3: The window covers exactly `cfg_slot_len_i` ticks, with `cfg_slot_len_i` at least 1. `slot_active_o` falls on the cycle after the tick that brings the elapsed count to slot start plus slot length.
- R4: The window opens and closes the same way whether `reply_pending_i` is 1 or 0.
- R5: `reply_go_o` is a one-cycle pulse in the first cycle of the window, given only when `reply_pending_i` is 1 in that cycle. It is never high outside the window.
- R6: `serve_group_o` is the group that owns the next request's slots. It steps by one on every accepted request start and wraps to 0 after `cfg_groups_i - 1`. A window opens only when `node_id_i >> cfg_q_log2_i` equals the group that was serving when the request was accepted.
- R7: A `sor_i` pulse that arrives while `slot_active_o` is 1 is ignored. The group does not step, and the window keeps the timing of its original reference.
- R8: A `sor_i` pulse that arrives while waiting for the slot is accepted. It latches a new reference, steps the group, and restarts the wait from the new reference.
- R9: After reset the block is in ST_IDLE with `slot_active_o`=0, `reply_go_o`=0 and `serve_group_o`=0. Ticks alone, with no request, never open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase strobe, advances the tick counter |
| sor_i | input | 1 | Start of a master request, one cycle |
| reply_pending_i | input | 1 | A queued reply is ready to send |
| node_id_i | input | ID_W | Node identity: upper bits select the group, low bits select the slot |
| cfg_q_log2_i | input | $clog2(ID_W+1) | Log2 of the number of slots per request |
| cfg_groups_i | input | ID_W | Number of groups in the rotation |
| cfg_offset_i | input | $clog2(TICK_MOD) | Ticks from request start to the first slot |
| cfg_slot_len_i | input | $clog2(TICK_MOD) | Ticks per slot |
| slot_active_o | output | 1 | Driver window for this node's slot |
| reply_go_o | output | 1 | Start-of-reply strobe |
| serve_group_o | output | ID_W | Group owning the next request's slots |

## Verification
The bound checker checks these properties on every cycle:
- The window never opens before the slot start and never runs past the slot end, measured against the elapsed count.
- The reply strobe is a single cycle inside the window and appears whenever a reply is pending as the window opens.
- The serving group stays below the configured count.
- The serving group cannot change while a window is open, even if a request start arrives.

The bench scenarios are needed to show the following:
- The slot lands on the exact tick predicted from the offset, slot index and slot length.
- The timing is unchanged when the reference sits just below the counter wrap.
- The rotation skips the node in foreign groups and serves it again after the groups wrap.
- A request start during the wait moves the slot later.

// File: rtl/slot_pkg.sv
package slot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_OPEN,
        ST_HOLD
    } sched_state_e;

endpackage

// File: rtl/slot_tick_cnt.sv
module slot_tick_cnt #(
    parameter int TICK_MOD = 200,
    localparam int TW = $clog2(TICK_MOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [TW-1:0] count_o
);

    localparam logic [TW-1:0] LAST = TW'(TICK_MOD - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (tick_i) begin
            count_o <= (count_o == LAST) ? '0 : count_o + 1'b1;
        end
    end

endmodule

// File: rtl/slot_elapsed.sv
module slot_elapsed #(
    parameter int TICK_MOD = 200,
    localparam int TW = $clog2(TICK_MOD)
) (
    input  logic [TW-1:0] now_i,
    input  logic [TW-1:0] base_i,
    output logic [TW-1:0] elapsed_o
);

    localparam logic [TW:0] MODV = (TW+1)'(TICK_MOD);

    logic [TW:0] now_x;
    logic [TW:0] base_x;
    logic [TW:0] diff_x;

    always_comb begin
        now_x  = {1'b0, now_i};
        base_x = {1'b0, base_i};
        if (now_i >= base_i) begin
            diff_x = now_x - base_x;
        end else begin
            // counter wrapped since the reference was taken
            diff_x = now_x + (MODV - base_x);
        end
        elapsed_o = diff_x[TW-1:0];
    end

endmodule

// File: rtl/slot_group_rot.sv
module slot_group_rot #(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic [ID_W-1:0] groups_i,
    output logic [ID_W-1:0] group_o
);

    logic [ID_W-1:0] nxt;

    always_comb begin
        nxt = group_o + 1'b1;
        if (nxt >= groups_i) begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_o <= '0;
        end else if (adv_i) begin
            group_o <= nxt;
        end
    end

endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_pkg::*;
#(
    parameter int TICK_MOD = 200,
    parameter int ID_W = 6,
    localparam int TW = $clog2(TICK_MOD),
    localparam int QW = $clog2(ID_W + 1),
    localparam int SW = ID_W + TW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            sor_i,
    input  logic            reply_pending_i,
    input  logic [ID_W-1:0] node_id_i,
    input  logic [QW-1:0]   cfg_q_log2_i,
    input  logic [ID_W-1:0] cfg_groups_i,
    input  logic [TW-1:0]   cfg_offset_i,
    input  logic [TW-1:0]   cfg_slot_len_i,
    output logic            slot_active_o,
    output logic            reply_go_o,
    output logic [ID_W-1:0] serve_group_o
);

    sched_state_e    state_q;
    sched_state_e    state_d;
    logic [TW-1:0]   now_cnt;
    logic [TW-1:0]   ref_q;
    logic [TW-1:0]   elapsed;
    logic [ID_W-1:0] my_group;
    logic [ID_W-1:0] my_slot;
    logic [SW-1:0]   slot_start;
    logic [SW-1:0]   slot_end;
    logic [SW-1:0]   elapsed_w;
    logic            in_window;
    logic            accept;
    logic            mine;

    slot_tick_cnt #(.TICK_MOD(TICK_MOD)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (now_cnt)
    );

    slot_elapsed #(.TICK_MOD(TICK_MOD)) u_el (
        .now_i     (now_cnt),
        .base_i    (ref_q),
        .elapsed_o (elapsed)
    );

    slot_group_rot #(.ID_W(ID_W)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (accept),
        .groups_i (cfg_groups_i),
        .group_o  (serve_group_o)
    );

    // slot geometry derived from identity and configuration
    always_comb begin
        my_group   = node_id_i >> cfg_q_log2_i;
        my_slot    = node_id_i & ~({ID_W{1'b1}} << cfg_q_log2_i);
        slot_start = SW'(cfg_offset_i) + SW'(my_slot) * SW'(cfg_slot_len_i);
        slot_end   = slot_start + SW'(cfg_slot_len_i);
        elapsed_w  = SW'(elapsed);
        in_window  = (state_q == ST_OPEN) || (state_q == ST_HOLD);
        accept     = sor_i && !in_window;
        mine       = (my_group == serve_group_o);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = mine ? ST_WAIT : ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (accept) begin
                    state_d = mine ? ST_WAIT : ST_IDLE;
                end else if (elapsed_w >= slot_start) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                state_d = (elapsed_w >= slot_end) ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (elapsed_w >= slot_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ref_q <= now_cnt;
            end
        end
    end

    // outputs
    always_comb begin
        slot_active_o = 1'b0;
        reply_go_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: ;
            ST_OPEN: begin
                slot_active_o = 1'b1;
                reply_go_o    = reply_pending_i;
            end
            ST_HOLD: slot_active_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int TW = 8,
    parameter int ID_W = 6,
    parameter int SW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sor_i,
    input logic            reply_pending_i,
    input logic            slot_active_o,
    input logic            reply_go_o,
    input logic [ID_W-1:0] serve_group_o,
    input logic [ID_W-1:0] cfg_groups_i,
    input logic [TW-1:0]   elapsed,
    input logic [SW-1:0]   slot_start,
    input logic [SW-1:0]   slot_end
);

    AST_NO_EARLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        slot_active_o |-> SW'(elapsed) >= slot_start); // R2

    AST_NO_LATE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_active_o |-> SW'(elapsed) <= slot_end); // R3

    AST_GO_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        reply_go_o |-> slot_active_o); // R5

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reply_go_o |=> !reply_go_o); // R5

    AST_GO_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(slot_active_o) && reply_pending_i) |-> reply_go_o); // R5

    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_groups_i != '0) |-> (serve_group_o < cfg_groups_i)); // R6

    AST_SOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_active_o && sor_i) |=> (serve_group_o == $past(serve_group_o))); // R7

endmodule

bind slot_sched slot_sched_chk #(.TW(TW), .ID_W(ID_W), .SW(SW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sor_i           (sor_i),
    .reply_pending_i (reply_pending_i),
    .slot_active_o   (slot_active_o),
    .reply_go_o      (reply_go_o),
    .serve_group_o   (serve_group_o),
    .cfg_groups_i    (cfg_groups_i),
    .elapsed         (elapsed),
    .slot_start      (slot_start),
    .slot_end        (slot_end)
);

// File: tb/sim_slot_sched.sv
module sim_slot_sched;

    localparam int MOD = 200;
    localparam int IDW = 6;
    localparam int NV  = 5;

    typedef struct packed {
        logic [5:0] node;
        logic [2:0] ql;
        logic [7:0] off;
        logic [7:0] len;
        logic [5:0] grp;
        logic       pend;
        logic [7:0] pre;
        logic [3:0] nmsg;
    } vec_t;

    // node, log2 slots, offset, slot length, groups, pending, pre-ticks, messages
    localparam vec_t TBL [NV] = '{
        '{6'd0, 3'd1, 8'd5, 8'd3, 6'd2, 1'b1, 8'd0,   4'd3},
        '{6'd3, 3'd1, 8'd4, 8'd2, 6'd2, 1'b0, 8'd190, 4'd2},
        '{6'd5, 3'd2, 8'd3, 8'd4, 6'd2, 1'b1, 8'd195, 4'd2},
        '{6'd2, 3'd0, 8'd2, 8'd1, 6'd3, 1'b1, 8'd0,   4'd4},
        '{6'd7, 3'd3, 8'd1, 8'd1, 6'd1, 1'b1, 8'd198, 4'd2}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tick;
    logic           sor;
    logic           pend;
    logic [IDW-1:0] node;
    logic [2:0]     ql;
    logic [IDW-1:0] grps;
    logic [7:0]     off;
    logic [7:0]     len;
    logic           act;
    logic           go;
    logic [IDW-1:0] sg;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    slot_sched #(.TICK_MOD(MOD), .ID_W(IDW)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick),
        .sor_i           (sor),
        .reply_pending_i (pend),
        .node_id_i       (node),
        .cfg_q_log2_i    (ql),
        .cfg_groups_i    (grps),
        .cfg_offset_i    (off),
        .cfg_slot_len_i  (len),
        .slot_active_o   (act),
        .reply_go_o      (go),
        .serve_group_o   (sg)
    );

    task automatic chk(input string tag, input int a, input int e);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, a, e);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        tick  = 1'b0;
        sor   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_sor();
        sor = 1'b1;
        @(negedge clk);
        sor = 1'b0;
    endtask

    task automatic set_cfg(input int n, input int q, input int o, input int l,
                           input int g, input bit p);
        node = IDW'(n);
        ql   = 3'(q);
        off  = 8'(o);
        len  = 8'(l);
        grps = IDW'(g);
        pend = p;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        tick  = 1'b0;
        sor   = 1'b0;
        set_cfg(0, 0, 1, 1, 1, 1'b1);
        @(negedge clk);

        // reset state
        do_reset();
        chk("R9 reset slot_active", int'(act), 0);
        chk("R9 reset reply_go", int'(go), 0);
        chk("R9 reset group", int'(sg), 0);
        for (int k = 0; k < 4; k++) begin
            do_tick();
            chk("R9 no window without request", int'(act), 0);
        end

        // table of scenarios
        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            int    st;
            int    en;
            int    myg;
            int    g;
            bit    mine;
            bit    ea;
            string tag;
            v = TBL[i];
            set_cfg(int'(v.node), int'(v.ql), int'(v.off), int'(v.len),
                    int'(v.grp), v.pend);
            do_reset();
            for (int p = 0; p < int'(v.pre); p++) do_tick();
            myg = int'(v.node) >> int'(v.ql);
            st  = int'(v.off) + (int'(v.node) & ((1 << int'(v.ql)) - 1)) * int'(v.len);
            en  = st + int'(v.len);
            g   = 0;
            for (int m = 0; m < int'(v.nmsg); m++) begin
                do_sor();
                mine = (g == myg);
                g    = (g + 1) % int'(v.grp);
                chk("R6 group step", int'(sg), g);
                chk("R2 closed at reference", int'(act), 0);
                for (int k = 1; k <= en + 1; k++) begin
                    do_tick();
                    ea = mine && (k >= st) && (k < en);
                    if (v.pre != 0)     tag = "R1 wrap window";
                    else if (!mine)     tag = "R6 foreign group";
                    else if (k < st)    tag = "R2 window start";
                    else if (k >= en)   tag = "R3 window end";
                    else if (!v.pend)   tag = "R4 window without reply";
                    else                tag = "R3 window held";
                    chk(tag, int'(act), int'(ea));
                    chk("R5 reply strobe", int'(go),
                        int'(mine && v.pend && (k == st)));
                end
            end
        end

        // request start during an open window is ignored
        set_cfg(0, 0, 3, 3, 2, 1'b1);
        do_reset();
        do_sor();
        chk("R6 group after first request", int'(sg), 1);
        for (int k = 1; k <= 3; k++) do_tick();
        chk("R7 window open", int'(act), 1);
        do_sor();
        chk("R7 group held", int'(sg), 1);
        chk("R7 window still open", int'(act), 1);
        chk("R5 no second strobe", int'(go), 0);
        do_tick();
        chk("R7 window at tick 4", int'(act), 1);
        do_tick();
        chk("R7 window at tick 5", int'(act), 1);
        do_tick();
        chk("R7 window closes on original reference", int'(act), 0);

        // request start during the wait restarts it
        set_cfg(0, 0, 4, 2, 1, 1'b0);
        do_reset();
        do_sor();
        do_tick();
        do_tick();
        do_sor();
        chk("R8 group wraps", int'(sg), 0);
        do_tick();
        do_tick();
        chk("R8 old slot start passes closed", int'(act), 0);
        do_tick();
        chk("R8 before new start", int'(act), 0);
        do_tick();
        chk("R8 opens from new reference", int'(act), 1);
        chk("R4 no strobe without reply", int'(go), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule